// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This combinational unit decides, in the same cycle its operands arrive, whether the program counter must leave sequential flow. It takes two register operands and a 5-bit select bus. The bus carries the 3-bit branch comparison code and two qualifiers: one marks a conditional branch, the other an unconditional jump.

Internally, a single two's-complement subtractor computes A + ~B + 1. A flag stage turns the difference, the carry-out and the operand sign bits into equal, unsigned-less-than and signed-less-than flags. An 8-way selector picks the condition named by the comparison code. Qualifier gating then produces the final decision. The three flags and the selected condition are also driven out as observation ports.

Top module: `branch_resolve`

## Requirements
- R1: The select bus `sel_i` is laid out as follows:
  - bits [2:0] hold the comparison code;
  - bit 3 is the branch qualifier;
  - bit 4 is the jump qualifier.
- R2: When bit 4 of `sel_i` is 1, `take_o` is 1 for every operand pair and every comparison code.
- R3: When bit 4 of `sel_i` is 0, `take_o` equals `cond_o` AND bit 3 of `sel_i`. In particular, `take_o` is 0 when neither qualifier is set.
- R4: `eq_o` is 1 exactly when the two operands are bit-for-bit equal, which means the difference is zero.
- R5: `ltu_o` is 1 exactly when `rs1_i` is below `rs2_i` as unsigned numbers. It is derived as the inverse of the subtractor carry-out.
- R6: `lts_o` is 1 exactly when `rs1_i` is below `rs2_i` as two's-complement numbers. When the sign bits differ it equals the sign of `rs1_i`; otherwise it equals `ltu_o`.
- R7: `cond_o` follows the comparison code:
  - 000 gives `eq_o` and 001 gives its inverse;
  - 100 gives `lts_o` and 101 gives its inverse;
  - 110 gives `ltu_o` and 111 gives its inverse.
- R8: Comparison codes 010 and 011 give `cond_o` = 0.
- R9: All outputs are combinational functions of the present inputs and are valid in the cycle the inputs are applied. The unit holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_i | input | 32 | First operand (A) |
| rs2_i | input | 32 | Second operand (B) |
| sel_i | input | 5 | {jump, branch, comparison code} |
| take_o | output | 1 | Redirect the program counter |
| eq_o | output | 1 | Operands equal |
| ltu_o | output | 1 | A below B, unsigned |
| lts_o | output | 1 | A below B, signed |
| cond_o | output | 1 | Condition chosen by the comparison code |

## Verification
The bench targets the two operand pairs where the signed and unsigned orders disagree: 0x80000000 against 0x7FFFFFFF, and 0 against 0xFFFFFFFF. A design that takes signed-less-than straight from the difference sign, or that inverts the carry wrongly, gets one of these orders backwards. It also targets equal operands, where a missing or misplaced inversion in the not-equal and greater-or-equal paths takes a branch that should fall through. Every one of the 32 select-bus values is applied to each corner pair. This catches a reserved code that leaks a flag, a branch qualifier that is ignored, and a jump that is mistakenly gated by the comparison.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SEL_W  = CODE_W + 2;

  typedef enum logic [CODE_W-1:0] {
    CMP_EQ   = 3'b000,
    CMP_NE   = 3'b001,
    CMP_RSV0 = 3'b010,
    CMP_RSV1 = 3'b011,
    CMP_LT   = 3'b100,
    CMP_GE   = 3'b101,
    CMP_LTU  = 3'b110,
    CMP_GEU  = 3'b111
  } cmp_code_e;

  typedef struct packed {
    logic      jmp;
    logic      br;
    cmp_code_e code;
  } sel_t;
endpackage

// File: rtl/branch_resolve_sub.sv
module branch_resolve_sub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] diff_o,
  output logic            cout_o
);
  logic [XLEN:0]   carry;
  logic [XLEN-1:0] b_inv;

  assign carry[0] = 1'b1;  // +1 of the two's-complement negate
  assign b_inv    = ~b_i;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    logic p;
    assign p          = a_i[i] ^ b_inv[i];
    assign diff_o[i]  = p ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_inv[i]) | (p & carry[i]);
  end

  assign cout_o = carry[XLEN];
endmodule

// File: rtl/branch_resolve_flags.sv
module branch_resolve_flags #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] diff_i,
  input  logic            cout_i,
  input  logic            a_sign_i,
  input  logic            b_sign_i,
  output logic            eq_o,
  output logic            ltu_o,
  output logic            lts_o
);
  logic sign_mismatch;

  assign eq_o          = ~|diff_i;
  assign ltu_o         = ~cout_i;  // borrow out of A - B
  assign sign_mismatch = a_sign_i ^ b_sign_i;
  assign lts_o         = sign_mismatch ? a_sign_i : ltu_o;
endmodule

// File: rtl/branch_resolve_cond.sv
module branch_resolve_cond
  import branch_resolve_pkg::*;
(
  input  cmp_code_e code_i,
  input  logic      eq_i,
  input  logic      ltu_i,
  input  logic      lts_i,
  output logic      cond_o
);
  localparam int unsigned NUM_CODES = 1 << CODE_W;

  logic [NUM_CODES-1:0] cand;

  always_comb begin
    cand           = '0;  // reserved codes stay 0
    cand[CMP_EQ]   = eq_i;
    cand[CMP_NE]   = ~eq_i;
    cand[CMP_LT]   = lts_i;
    cand[CMP_GE]   = ~lts_i;
    cand[CMP_LTU]  = ltu_i;
    cand[CMP_GEU]  = ~ltu_i;
  end

  assign cond_o = cand[code_i];
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_resolve_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             take_o,
  output logic             eq_o,
  output logic             ltu_o,
  output logic             lts_o,
  output logic             cond_o
);
  localparam int unsigned MSB = XLEN - 1;

  sel_t            sel;
  logic [XLEN-1:0] diff;
  logic            cout;

  assign sel = sel_t'(sel_i);

  branch_resolve_sub #(.XLEN(XLEN)) u_sub (
    .a_i    (rs1_i),
    .b_i    (rs2_i),
    .diff_o (diff),
    .cout_o (cout)
  );

  branch_resolve_flags #(.XLEN(XLEN)) u_flags (
    .diff_i   (diff),
    .cout_i   (cout),
    .a_sign_i (rs1_i[MSB]),
    .b_sign_i (rs2_i[MSB]),
    .eq_o     (eq_o),
    .ltu_o    (ltu_o),
    .lts_o    (lts_o)
  );

  branch_resolve_cond u_cond (
    .code_i (sel.code),
    .eq_i   (eq_o),
    .ltu_i  (ltu_o),
    .lts_i  (lts_o),
    .cond_o (cond_o)
  );

  // jump bypasses the comparison entirely
  assign take_o = sel.jmp | (sel.br & cond_o);
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [4:0]      sel_i,
  input logic            take_o,
  input logic            eq_o,
  input logic            ltu_o,
  input logic            lts_o,
  input logic            cond_o
);
  // Purely combinational block: immediate checks on settled values.
  always_comb begin
    if (sel_i[4]) begin
      assert_jump_taken_R2: assert (take_o) else $error("jump not taken");
    end else begin
      assert_gated_branch_R3: assert (take_o == (sel_i[3] & cond_o)) else $error("gating");
    end
    assert_eq_flag_R4: assert (eq_o == (rs1_i == rs2_i)) else $error("eq flag");
    assert_ltu_flag_R5: assert (ltu_o == (rs1_i < rs2_i)) else $error("ltu flag");
    assert_lts_flag_R6: assert (lts_o == ($signed(rs1_i) < $signed(rs2_i))) else $error("lts flag");
    if (sel_i[2:0] == 3'b001) begin
      assert_ne_cond_R7: assert (cond_o == !eq_o) else $error("ne cond");
    end
    if (sel_i[2:0] == 3'b101) begin
      assert_ge_cond_R7: assert (cond_o == !lts_o) else $error("ge cond");
    end
    if (sel_i[2:1] == 2'b01) begin
      assert_reserved_zero_R8: assert (!cond_o) else $error("reserved code");
    end
  end
endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN)) u_chk (
  .rs1_i  (rs1_i),
  .rs2_i  (rs2_i),
  .sel_i  (sel_i),
  .take_o (take_o),
  .eq_o   (eq_o),
  .ltu_o  (ltu_o),
  .lts_o  (lts_o),
  .cond_o (cond_o)
);

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rs1, rs2;
  logic [4:0]  sel;
  logic        take, eq, ltu, lts, cond;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  branch_resolve dut (
    .rs1_i  (rs1),
    .rs2_i  (rs2),
    .sel_i  (sel),
    .take_o (take),
    .eq_o   (eq),
    .ltu_o  (ltu),
    .lts_o  (lts),
    .cond_o (cond)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rs1=%h rs2=%h sel=%b act=%b exp=%b", req, rs1, rs2, sel, act, exp);
    end
  endtask

  // Behavioural reference: native comparisons, sel layout per R1.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s);
    logic m_eq, m_ltu, m_lts, m_cond, m_take;
    @(negedge clk);
    rs1 = a; rs2 = b; sel = s;
    #1;  // same cycle, no clock edge in between (R9)
    m_eq  = (a == b);
    m_ltu = (a < b);
    m_lts = ($signed(a) < $signed(b));
    case (s[2:0])
      3'b000: m_cond = m_eq;
      3'b001: m_cond = !m_eq;
      3'b100: m_cond = m_lts;
      3'b101: m_cond = !m_lts;
      3'b110: m_cond = m_ltu;
      3'b111: m_cond = !m_ltu;
      default: m_cond = 1'b0;
    endcase
    m_take = s[4] | (s[3] & m_cond);
    chk("R4 eq", eq, m_eq);
    chk("R5 ltu", ltu, m_ltu);
    chk("R6 lts", lts, m_lts);
    chk((s[2:1] == 2'b01) ? "R8 reserved cond" : "R7 cond", cond, m_cond);
    chk(s[4] ? "R2 jump take" : "R3 gated take (R9 same cycle)", take, m_take);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ca [9];
    logic [31:0] cb [9];
    ca = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h5, 32'h0, 32'hFFFF_FFFF,
           32'h0, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFE};
    cb = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h5, 32'hFFFF_FFFF, 32'h0,
           32'h0, 32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFF};
    rs1 = '0; rs2 = '0; sel = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: zero operands, no qualifier -> not taken (R3)
    apply(32'h0, 32'h0, 5'b00000);
    // every select value on every corner pair (R1)
    for (int p = 0; p < 9; p++)
      for (int s = 0; s < 32; s++)
        apply(ca[p], cb[p], 5'(s));
    // random operands, occasional forced equality
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = (k % 7 == 0) ? a : $urandom();
      apply(a, b, 5'($urandom_range(0, 31)));
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule